// File: doc/BRIEF.md
# Register Rename Map Table

This block translates architectural register numbers into physical register tags for a small out-of-order core that renames one instruction per cycle. Each instruction can have up to two source operands and one optional destination. A source that names a register is looked up in the speculative map. A source that carries an immediate bypasses the map and comes back unchanged. For a destination, the block takes a fresh physical tag from a pool of free tags, records it as the new mapping, and returns both the new tag and the tag it displaces. The displaced tag travels with the instruction. It is returned to the block when that instruction retires.

Retirement drives the commit port. The commit port updates a second, committed copy of the map and releases the displaced tag back to the pool. A physical register is therefore recycled only after a newer mapping of the same architectural register has retired. This direct remapping removes write-after-write and write-after-read conflicts, and it leaves read-after-write dependencies pointing at the producer's tag. A flush throws away all speculative state: the committed map becomes the speculative map, and the pool is rebuilt from the tags that the committed map does not hold.

Top module: `reg_rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical tag i and that entry is marked unwritten. Tags NUM_LOG to NUM_PHYS-1 (8 to 15 by default) are free. A lookup of any register returns tag i with the mapped flag low.
- R2: A register source returns the tag currently held in the speculative map. Its mapped flag is high only if that register has been a renamed destination since reset, or is held by the committed map after a flush.
- R3: A source whose immediate flag is high returns its 3-bit index zero-extended into the tag output, with the mapped flag low. The map is not consulted.
- R4: A renamed destination receives the lowest-numbered free tag and returns the previously mapped tag on the old-tag output, in the same cycle. The map holds the new tag from the next cycle. Sources of the same instruction still see the old mapping.
- R5: When no tag is free, ready stays low for an instruction that has a destination, and neither the map nor the pool changes. An instruction without a destination is still accepted.
- R6: A commit writes its new tag into the committed map and releases its old tag. A rename and a commit in the same cycle both take effect. The released tag can be allocated from the next cycle, not in the same cycle.
- R7: During a flush, ready is low. From the next cycle the speculative map and its mapped flags equal the committed map, including a commit made in the flush cycle. The free pool then holds exactly the tags that the committed map does not reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 1 | Rename request valid |
| ren_ready_o | output | 1 | Rename request accepted this cycle |
| src0_imm_i | input | 1 | Source 0 is an immediate |
| src0_idx_i | input | 3 | Source 0 register index or immediate value |
| src0_tag_o | output | 4 | Source 0 physical tag or passed-through immediate |
| src0_mapped_o | output | 1 | Source 0 names a written register |
| src1_imm_i | input | 1 | Source 1 is an immediate |
| src1_idx_i | input | 3 | Source 1 register index or immediate value |
| src1_tag_o | output | 4 | Source 1 physical tag or passed-through immediate |
| src1_mapped_o | output | 1 | Source 1 names a written register |
| dst_en_i | input | 1 | Instruction writes a destination |
| dst_idx_i | input | 3 | Destination register index |
| dst_tag_o | output | 4 | Newly allocated physical tag |
| dst_old_tag_o | output | 4 | Tag displaced by the new mapping |
| cmt_valid_i | input | 1 | Retiring instruction with a destination |
| cmt_idx_i | input | 3 | Destination register of the retiring instruction |
| cmt_new_tag_i | input | 4 | Tag the retiring instruction was given |
| cmt_old_tag_i | input | 4 | Tag the retiring instruction displaced |
| flush_i | input | 1 | Discard speculative state |

## Verification
The first coincidence tested is a commit arriving in the same cycle as an allocation. The bench drains the pool to its last free tag, then renames a destination while committing an instruction whose old tag (1) is lower than that last tag (15). The rename must receive 15, not the just-released 1, and the following rename must receive 1. The second coincidence is a commit in the same cycle as a flush. The later lookups and allocations must reflect that commit in both the restored map and the rebuilt pool.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int unsigned RN_LOG_REGS  = 8;
  localparam int unsigned RN_PHYS_REGS = 16;
endpackage

// File: rtl/rename_free_pool.sv
module rename_free_pool #(
  parameter int unsigned NUM_LOG  = rename_pkg::RN_LOG_REGS,
  parameter int unsigned NUM_PHYS = rename_pkg::RN_PHYS_REGS,
  localparam int unsigned TAG_W   = $clog2(NUM_PHYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alloc_i,
  input  logic                rel_i,
  input  logic [TAG_W-1:0]    rel_tag_i,
  input  logic                rebuild_i,
  input  logic [NUM_PHYS-1:0] live_i,
  output logic                empty_o,
  output logic [TAG_W-1:0]    alloc_tag_o
);

  logic [NUM_PHYS-1:0] free_q, free_d;

  // lowest free index wins
  always_comb begin
    alloc_tag_o = '0;
    for (int j = NUM_PHYS - 1; j >= 0; j--) begin
      if (free_q[j]) alloc_tag_o = TAG_W'(j);
    end
  end

  assign empty_o = (free_q == '0);

  always_comb begin
    free_d = free_q;
    if (rebuild_i) begin
      free_d = ~live_i;
    end else begin
      if (alloc_i) free_d[alloc_tag_o] = 1'b0;
      if (rel_i)   free_d[rel_tag_i]   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < NUM_PHYS; j++) free_q[j] <= (j >= NUM_LOG);
    end else begin
      free_q <= free_d;
    end
  end

  a_r6_no_double_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !rebuild_i) |-> !free_q[rel_tag_i]);

  a_r5_no_alloc_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !empty_o);

  a_r6_alloc_leaves_pool: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !rebuild_i && !(rel_i && rel_tag_i == alloc_tag_o))
      |=> !free_q[$past(alloc_tag_o)]);

endmodule

// File: rtl/rename_map_store.sv
module rename_map_store #(
  parameter int unsigned NUM_LOG  = rename_pkg::RN_LOG_REGS,
  parameter int unsigned NUM_PHYS = rename_pkg::RN_PHYS_REGS,
  localparam int unsigned TAG_W   = $clog2(NUM_PHYS),
  localparam int unsigned LOG_W   = $clog2(NUM_LOG)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic [LOG_W-1:0]               wr_idx_i,
  input  logic [TAG_W-1:0]               wr_tag_i,
  input  logic                           load_i,
  input  logic [NUM_LOG-1:0][TAG_W-1:0]  load_tags_i,
  input  logic [NUM_LOG-1:0]             load_vld_i,
  output logic [NUM_LOG-1:0][TAG_W-1:0]  tags_o,
  output logic [NUM_LOG-1:0]             vld_o
);

  for (genvar g = 0; g < NUM_LOG; g++) begin : g_entry
    logic [TAG_W-1:0] tag_d;
    logic             vld_d;

    always_comb begin
      tag_d = tags_o[g];
      vld_d = vld_o[g];
      if (load_i) begin
        tag_d = load_tags_i[g];
        vld_d = load_vld_i[g];
      end else if (wr_i && wr_idx_i == LOG_W'(g)) begin
        tag_d = wr_tag_i;
        vld_d = 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tags_o[g] <= TAG_W'(g);
        vld_o[g]  <= 1'b0;
      end else begin
        tags_o[g] <= tag_d;
        vld_o[g]  <= vld_d;
      end
    end
  end

endmodule

// File: rtl/reg_rename_map.sv
module reg_rename_map #(
  parameter int unsigned NUM_LOG  = rename_pkg::RN_LOG_REGS,
  parameter int unsigned NUM_PHYS = rename_pkg::RN_PHYS_REGS,
  localparam int unsigned TAG_W   = $clog2(NUM_PHYS),
  localparam int unsigned LOG_W   = $clog2(NUM_LOG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ren_valid_i,
  output logic             ren_ready_o,
  input  logic             src0_imm_i,
  input  logic [LOG_W-1:0] src0_idx_i,
  output logic [TAG_W-1:0] src0_tag_o,
  output logic             src0_mapped_o,
  input  logic             src1_imm_i,
  input  logic [LOG_W-1:0] src1_idx_i,
  output logic [TAG_W-1:0] src1_tag_o,
  output logic             src1_mapped_o,
  input  logic             dst_en_i,
  input  logic [LOG_W-1:0] dst_idx_i,
  output logic [TAG_W-1:0] dst_tag_o,
  output logic [TAG_W-1:0] dst_old_tag_o,
  input  logic             cmt_valid_i,
  input  logic [LOG_W-1:0] cmt_idx_i,
  input  logic [TAG_W-1:0] cmt_new_tag_i,
  input  logic [TAG_W-1:0] cmt_old_tag_i,
  input  logic             flush_i
);

  logic [NUM_LOG-1:0][TAG_W-1:0] spec_tags, cmt_tags, cmt_tags_nxt;
  logic [NUM_LOG-1:0]            spec_vld, cmt_vld, cmt_vld_nxt;
  logic [NUM_PHYS-1:0]           live_nxt;
  logic                          pool_empty;
  logic                          ren_fire, alloc;

  assign ren_ready_o = !flush_i && (!dst_en_i || !pool_empty);
  assign ren_fire    = ren_valid_i && ren_ready_o;
  assign alloc       = ren_fire && dst_en_i;

  // immediates bypass the lookup
  assign src0_tag_o    = src0_imm_i ? TAG_W'(src0_idx_i) : spec_tags[src0_idx_i];
  assign src0_mapped_o = !src0_imm_i && spec_vld[src0_idx_i];
  assign src1_tag_o    = src1_imm_i ? TAG_W'(src1_idx_i) : spec_tags[src1_idx_i];
  assign src1_mapped_o = !src1_imm_i && spec_vld[src1_idx_i];
  assign dst_old_tag_o = spec_tags[dst_idx_i];

  // committed view including this cycle's retirement
  always_comb begin
    cmt_tags_nxt = cmt_tags;
    cmt_vld_nxt  = cmt_vld;
    if (cmt_valid_i) begin
      cmt_tags_nxt[cmt_idx_i] = cmt_new_tag_i;
      cmt_vld_nxt[cmt_idx_i]  = 1'b1;
    end
  end

  always_comb begin
    live_nxt = '0;
    for (int i = 0; i < NUM_LOG; i++) live_nxt[cmt_tags_nxt[i]] = 1'b1;
  end

  rename_map_store #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) i_spec_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (alloc),
    .wr_idx_i    (dst_idx_i),
    .wr_tag_i    (dst_tag_o),
    .load_i      (flush_i),
    .load_tags_i (cmt_tags_nxt),
    .load_vld_i  (cmt_vld_nxt),
    .tags_o      (spec_tags),
    .vld_o       (spec_vld)
  );

  rename_map_store #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) i_cmt_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (1'b0),
    .wr_idx_i    ('0),
    .wr_tag_i    ('0),
    .load_i      (1'b1),
    .load_tags_i (cmt_tags_nxt),
    .load_vld_i  (cmt_vld_nxt),
    .tags_o      (cmt_tags),
    .vld_o       (cmt_vld)
  );

  rename_free_pool #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) i_pool (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (alloc),
    .rel_i       (cmt_valid_i),
    .rel_tag_i   (cmt_old_tag_i),
    .rebuild_i   (flush_i),
    .live_i      (live_nxt),
    .empty_o     (pool_empty),
    .alloc_tag_o (dst_tag_o)
  );

  a_r4_map_takes_new_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc |=> (spec_tags[$past(dst_idx_i)] == $past(dst_tag_o)) && spec_vld[$past(dst_idx_i)]);

  a_r5_stall_holds_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && dst_en_i && !ren_ready_o && !flush_i) |=> $stable(spec_tags) && $stable(spec_vld));

  a_r7_flush_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (spec_tags == cmt_tags) && (spec_vld == cmt_vld));

  a_r3_imm_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src0_imm_i |-> !src0_mapped_o && (src0_tag_o == TAG_W'(src0_idx_i)));

endmodule

// File: tb/test_reg_rename_map.sv
`timescale 1ns/1ps
module test_reg_rename_map;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ren_valid = 1'b0, src0_imm = 1'b0, src1_imm = 1'b0, dst_en = 1'b0;
  logic [2:0] src0_idx = '0, src1_idx = '0, dst_idx = '0, cmt_idx = '0;
  logic       cmt_valid = 1'b0, flush = 1'b0;
  logic [3:0] cmt_new = '0, cmt_old = '0;
  logic       ready, s0_map, s1_map;
  logic [3:0] s0_tag, s1_tag, d_tag, d_old;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  reg_rename_map i_reg_rename_map (
    .clk_i(clk), .rst_ni(rst_n),
    .ren_valid_i(ren_valid), .ren_ready_o(ready),
    .src0_imm_i(src0_imm), .src0_idx_i(src0_idx), .src0_tag_o(s0_tag), .src0_mapped_o(s0_map),
    .src1_imm_i(src1_imm), .src1_idx_i(src1_idx), .src1_tag_o(s1_tag), .src1_mapped_o(s1_map),
    .dst_en_i(dst_en), .dst_idx_i(dst_idx), .dst_tag_o(d_tag), .dst_old_tag_o(d_old),
    .cmt_valid_i(cmt_valid), .cmt_idx_i(cmt_idx), .cmt_new_tag_i(cmt_new),
    .cmt_old_tag_i(cmt_old), .flush_i(flush)
  );

  typedef struct packed {
    logic       s0imm; logic [2:0] s0idx;
    logic       s1imm; logic [2:0] s1idx;
    logic       den;   logic [2:0] didx;
    logic [3:0] e_s0;  logic       e_s0v;
    logic [3:0] e_s1;  logic       e_s1v;
    logic [3:0] e_new; logic [3:0] e_old;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0,3'd1, 1'b1,3'd5, 1'b1,3'd1, 4'd1,1'b0, 4'd5,1'b0, 4'd8, 4'd1},
    '{1'b0,3'd1, 1'b0,3'd2, 1'b1,3'd2, 4'd8,1'b1, 4'd2,1'b0, 4'd9, 4'd2},
    '{1'b0,3'd2, 1'b0,3'd1, 1'b1,3'd1, 4'd9,1'b1, 4'd8,1'b1, 4'd10,4'd8},
    '{1'b1,3'd7, 1'b0,3'd1, 1'b0,3'd0, 4'd7,1'b0, 4'd10,1'b1,4'd0, 4'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic v, input logic i0, input logic [2:0] x0,
                       input logic i1, input logic [2:0] x1,
                       input logic de, input logic [2:0] dx);
    @(negedge clk);
    ren_valid = v; src0_imm = i0; src0_idx = x0; src1_imm = i1; src1_idx = x1;
    dst_en = de; dst_idx = dx;
    #1;
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog timeout");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state, no fire
    setup(1'b0, 1'b0, 3'd0, 1'b0, 3'd7, 1'b1, 3'd0);
    chk("R1 ready", ready, 1);
    chk("R1 s0 tag", s0_tag, 0);
    chk("R1 s0 mapped", s0_map, 0);
    chk("R1 s1 tag", s1_tag, 7);
    chk("R1 first free", d_tag, 8);

    // table walk: R2 R3 R4
    foreach (VECS[k]) begin
      setup(1'b1, VECS[k].s0imm, VECS[k].s0idx, VECS[k].s1imm, VECS[k].s1idx,
            VECS[k].den, VECS[k].didx);
      chk(VECS[k].s0imm ? "R3 s0 tag" : "R2 s0 tag", s0_tag, VECS[k].e_s0);
      chk(VECS[k].s0imm ? "R3 s0 map" : "R2 s0 map", s0_map, VECS[k].e_s0v);
      chk(VECS[k].s1imm ? "R3 s1 tag" : "R2 s1 tag", s1_tag, VECS[k].e_s1);
      chk(VECS[k].s1imm ? "R3 s1 map" : "R2 s1 map", s1_map, VECS[k].e_s1v);
      chk("R4 ready", ready, 1);
      if (VECS[k].den) begin
        chk("R4 new tag", d_tag, VECS[k].e_new);
        chk("R4 old tag", d_old, VECS[k].e_old);
      end
    end

    // drain pool with r4 (R4 lowest first)
    for (int k = 0; k < 4; k++) begin
      setup(1'b1, 1'b0, 3'd4, 1'b0, 3'd0, 1'b1, 3'd4);
      chk("R4 drain new", d_tag, 11 + k);
      chk("R4 drain old", d_old, (k == 0) ? 4 : 10 + k);
      chk("R2 chain src", s0_tag, (k == 0) ? 4 : 10 + k);
    end

    // R6 commit and allocate in one cycle
    setup(1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd4);
    cmt_valid = 1'b1; cmt_idx = 3'd1; cmt_new = 4'd8; cmt_old = 4'd1;
    #0.5;
    chk("R6 same-cycle alloc", d_tag, 15);
    chk("R6 same-cycle old", d_old, 14);
    setup(1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd5);
    cmt_valid = 1'b0;
    #0.5;
    chk("R6 released next", d_tag, 1);
    chk("R6 released old", d_old, 5);

    // R5 stall when empty
    setup(1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd6);
    chk("R5 stall ready", ready, 0);
    setup(1'b1, 1'b0, 3'd6, 1'b0, 3'd5, 1'b0, 3'd0);
    chk("R5 no-dst ready", ready, 1);
    chk("R5 map unchanged tag", s0_tag, 6);
    chk("R5 map unchanged flag", s0_map, 0);
    chk("R5 prior map", s1_tag, 1);

    // R7 flush with commit in same cycle
    setup(1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd3);
    flush = 1'b1; cmt_valid = 1'b1; cmt_idx = 3'd2; cmt_new = 4'd9; cmt_old = 4'd2;
    #0.5;
    chk("R7 flush ready", ready, 0);
    setup(1'b1, 1'b0, 3'd4, 1'b0, 3'd1, 1'b1, 3'd3);
    flush = 1'b0; cmt_valid = 1'b0;
    #0.5;
    chk("R7 restored r4 tag", s0_tag, 4);
    chk("R7 restored r4 flag", s0_map, 0);
    chk("R7 restored r1", s1_tag, 8);
    chk("R7 rebuilt alloc", d_tag, 1);
    chk("R7 old after flush", d_old, 3);
    setup(1'b1, 1'b0, 3'd2, 1'b0, 3'd3, 1'b1, 3'd3);
    chk("R7 flush-cycle commit", s0_tag, 9);
    chk("R7 flush-cycle flag", s0_map, 1);
    chk("R4 after flush src", s1_tag, 1);
    chk("R7 rebuilt second", d_tag, 2);
    chk("R4 old after flush", d_old, 1);

    setup(1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0);
    @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule